// File: doc/BRIEF.md
# Segmented DAC Input Decoder Pipeline

This block is the digital front end of an 8-bit current-steering converter. A straight-binary input code is registered on the rising clock edge. Its upper four bits are then decoded into a fifteen-wire unary (thermometer) vector, and its lower four bits are kept as binary-weighted enables. The result is re-registered on the falling edge of the same clock, so the two stages sit half a cycle apart and the switch enables change only at falling edges. The analog cells driven by these enables are outside the block. Here the conversion result is the sum of the enabled weights: each unary wire counts 16 LSB and binary wire i counts 2^i LSB.

An active-high power-down input forces every enable low and clears both pipeline stages. When power-down falls, operation resumes with the first code captured after the release. An asynchronous active-low reset clears the pipeline. Its release is synchronised to the clock inside the block.

Top module: `segdac_frontend`

## Requirements
- R1: While reset is asserted, and until the first code has been captured after reset is released, all unary and binary enables are 0.
- R2: Bit 7 of `code_in` is the MSB and bit 0 the LSB. Bits 7:4 form the unary field and bits 3:0 the binary field. Bit i of `bin_en` equals bit i of the captured code and carries weight 2^i LSB.
- R3: For an upper field value k from 0 to 15, `unary_en` has exactly its k lowest bits set and all other bits clear. Each set bit carries weight 16 LSB.
- R4: A code sampled at a rising edge reaches the outputs at the following falling edge. It stays there unchanged until the next falling edge, whatever `code_in` does in between.
- R5: Code 0x00 gives no enabled wire (weight 0). Code 0xFF gives all 15 unary and all 4 binary wires enabled (weight 255).
- R6: For every code from 0 to 255, the weight sum equals the code, so the weight never drops as the code increases.
- R7: From the first falling edge at which `pwr_dn` is high, all enables are 0, and `code_in` has no effect while `pwr_dn` stays high.
- R8: After `pwr_dn` falls, no code that was present before or during power-down appears. The first code captured at a rising edge with `pwr_dn` low appears at the falling edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; capture on rising edge, launch on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Active-high power-down |
| code_in | input | 8 | Straight-binary input code |
| unary_en | output | 15 | Thermometer enables, 16 LSB each |
| bin_en | output | 4 | Binary enables, bit i weighs 2^i LSB |

## Verification
The bench drives a code 2 ns after a rising edge. That edge is followed by the capturing rising edge and then the launching falling edge, so the result is due 1.5 cycles after the drive. The bench samples 2 ns after that falling edge. To confirm the half-cycle hold, it drives a new code and samples 1 ns later, while the old value must still be present. Power-down takes effect at the first falling edge it covers, 3 ns after it is driven, and is sampled 2 ns past that edge. After release, the bench samples both at the falling edge that precedes the first new capture, where the outputs must be zero, and 1.5 cycles after the release, where the first new code must be present.

// File: rtl/segdac_pkg.sv
`timescale 1ns/1ps
package segdac_pkg;
  localparam int DEF_UNARY_W = 4;
  localparam int DEF_BIN_W   = 4;

  typedef enum logic {
    STAGE_RUN  = 1'b0,
    STAGE_IDLE = 1'b1
  } stage_mode_e;
endpackage

// File: rtl/segdac_rst_sync.sv
`timescale 1ns/1ps
module segdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/segdac_capture.sv
`timescale 1ns/1ps
module segdac_capture
  import segdac_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);
  stage_mode_e       mode;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    mode = pwr_dn ? STAGE_IDLE : STAGE_RUN;
    unique case (mode)
      STAGE_IDLE: code_d = '0;
      default:    code_d = code_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/segdac_therm.sv
`timescale 1ns/1ps
module segdac_therm #(
  parameter int IN_W  = 4,
  localparam int OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  level,
  output logic [OUT_W-1:0] therm
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_cell
    assign therm[i] = (level > IN_W'(i));
  end
endmodule

// File: rtl/segdac_launch.sv
`timescale 1ns/1ps
module segdac_launch
  import segdac_pkg::*;
#(
  parameter int UNARY_N = 15,
  parameter int BIN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_dn,
  input  logic [UNARY_N-1:0] unary_d,
  input  logic [BIN_W-1:0]   bin_d,
  output logic [UNARY_N-1:0] unary_q,
  output logic [BIN_W-1:0]   bin_q
);
  stage_mode_e        mode;
  logic [UNARY_N-1:0] unary_nx;
  logic [BIN_W-1:0]   bin_nx;

  always_comb begin
    mode = pwr_dn ? STAGE_IDLE : STAGE_RUN;
    unique case (mode)
      STAGE_IDLE: begin
        unary_nx = '0;
        bin_nx   = '0;
      end
      default: begin
        unary_nx = unary_d;
        bin_nx   = bin_d;
      end
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unary_q <= '0;
      bin_q   <= '0;
    end else begin
      unary_q <= unary_nx;
      bin_q   <= bin_nx;
    end
  end
endmodule

// File: rtl/segdac_frontend.sv
`timescale 1ns/1ps
module segdac_frontend
  import segdac_pkg::*;
#(
  parameter int UNARY_W = DEF_UNARY_W,
  parameter int BIN_W   = DEF_BIN_W,
  localparam int CODE_W  = UNARY_W + BIN_W,
  localparam int UNARY_N = (1 << UNARY_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_dn,
  input  logic [CODE_W-1:0]  code_in,
  output logic [UNARY_N-1:0] unary_en,
  output logic [BIN_W-1:0]   bin_en
);
  logic               rst_q_n;
  logic [CODE_W-1:0]  code_q;
  logic [UNARY_N-1:0] therm;

  segdac_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  segdac_capture #(.CODE_W(CODE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .pwr_dn  (pwr_dn),
    .code_in (code_in),
    .code_q  (code_q)
  );

  segdac_therm #(.IN_W(UNARY_W)) u_therm (
    .level (code_q[CODE_W-1:BIN_W]),
    .therm (therm)
  );

  segdac_launch #(.UNARY_N(UNARY_N), .BIN_W(BIN_W)) u_launch (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .pwr_dn  (pwr_dn),
    .unary_d (therm),
    .bin_d   (code_q[BIN_W-1:0]),
    .unary_q (unary_en),
    .bin_q   (bin_en)
  );
endmodule

// File: rtl/segdac_frontend_chk.sv
`timescale 1ns/1ps
module segdac_frontend_chk #(
  parameter int UNARY_W = 4,
  parameter int BIN_W   = 4,
  localparam int CODE_W  = UNARY_W + BIN_W,
  localparam int UNARY_N = (1 << UNARY_W) - 1
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               pwr_dn,
  input logic [CODE_W-1:0]  code_in,
  input logic [UNARY_N-1:0] unary_en,
  input logic [BIN_W-1:0]   bin_en
);
  logic [UNARY_N:0] u_ext;
  int               weight;

  always_comb begin
    u_ext  = {1'b0, unary_en};
    weight = $countones(unary_en) * (1 << BIN_W) + int'(bin_en);
  end

  // R3
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (((u_ext + 1'b1) & u_ext) == '0));

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pwr_dn && $past(pwr_dn)) |-> (unary_en == '0 && bin_en == '0));

  // R6
  weight_match_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && !$past(pwr_dn) && !pwr_dn) |-> (weight == int'($past(code_in))));

  // R5
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && !$past(pwr_dn) && !pwr_dn && (&$past(code_in)))
      |-> ((&unary_en) && (&bin_en)));
endmodule

bind segdac_frontend segdac_frontend_chk #(.UNARY_W(UNARY_W), .BIN_W(BIN_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .pwr_dn   (pwr_dn),
  .code_in  (code_in),
  .unary_en (unary_en),
  .bin_en   (bin_en)
);

// File: tb/segdac_frontend_test.sv
`timescale 1ns/1ps
module segdac_frontend_test;
  logic        clk;
  logic        rst_n;
  logic        pwr_dn;
  logic [7:0]  code_in;
  logic [14:0] unary_en;
  logic [3:0]  bin_en;

  int checks;
  int fails;
  bit done;

  segdac_frontend uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .code_in  (code_in),
    .unary_en (unary_en),
    .bin_en   (bin_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [14:0] exp_therm(input logic [3:0] k);
    logic [15:0] m;
    m = (16'd1 << k) - 16'd1;
    return m[14:0];
  endfunction

  task automatic check_code(input string req, input logic [7:0] v);
    logic [14:0] eu;
    eu = exp_therm(v[7:4]);
    checks++;
    if (unary_en !== eu || bin_en !== v[3:0]) begin
      fails++;
      $display("FAIL %s: unary=%h bin=%h expected unary=%h bin=%h",
               req, unary_en, bin_en, eu, v[3:0]);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    @(posedge clk);
    #2 code_in = v;
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0; pwr_dn = 1'b0; code_in = 8'h00;
    repeat (3) @(posedge clk);
    #7 check_code("R1 in reset", 8'h00);
    code_in = 8'hA7;
    @(posedge clk);
    #2 rst_n = 1'b1;
    #5 check_code("R1 after release", 8'h00);
    code_in = 8'h00;
    repeat (4) @(posedge clk);
    #7 check_code("R1 settled", 8'h00);
  endtask

  // R2 R3 R5 R6
  task automatic t_sweep();
    int prev_w;
    prev_w = -1;
    for (int v = 0; v < 256; v++) begin
      int w;
      apply(8'(v));
      @(posedge clk);
      #7;
      w = $countones(unary_en) * 16 + int'(bin_en);
      check_code("R2 R3 sweep", 8'(v));
      checks++;
      if (w != v || w < prev_w) begin
        fails++;
        $display("FAIL R6: weight=%0d expected=%0d", w, v);
      end
      if (v == 0 || v == 255) check_code("R5 endpoint", 8'(v));
      prev_w = w;
    end
  endtask

  // R4
  task automatic t_hold();
    apply(8'h3C);
    @(posedge clk);
    #7 check_code("R4 launch", 8'h3C);
    apply(8'hE1);
    #1 check_code("R4 hold before falling edge", 8'h3C);
    @(posedge clk);
    #7 check_code("R4 next launch", 8'hE1);
  endtask

  // R7 R8
  task automatic t_powerdown();
    apply(8'h5A);
    @(posedge clk);
    #7 check_code("R7 pre", 8'h5A);
    @(posedge clk);
    #2 begin pwr_dn = 1'b1; code_in = 8'hC3; end
    #5 check_code("R7 forced low", 8'h00);
    apply(8'hFF);
    @(posedge clk);
    #7 check_code("R7 code ignored", 8'h00);
    @(posedge clk);
    #2 begin pwr_dn = 1'b0; code_in = 8'h96; end
    #5 check_code("R8 no stale code", 8'h00);
    @(posedge clk);
    #7 check_code("R8 first new code", 8'h96);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    t_reset();
    t_sweep();
    t_hold();
    t_powerdown();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule